// File: doc/BRIEF.md
# Next-PC Unit with Branch Delay Slot

This block chooses the address of the next instruction for a 32-bit load-store processor that executes one instruction per clock. Each cycle it sees the address of the instruction now executing, that instruction's word, and the values read for its two source register fields. From these it returns the next fetch address. When a link-type transfer is present, it also returns a write strobe and a return address bound for register 31.

Control transfers are delayed by one instruction. When a branch or jump takes effect, the instruction placed after it (the delay slot) still executes, and only then does fetch move to the target. The unit resolves the condition and computes the target while the transfer itself executes. It then parks the target in a pending register.

A two-state machine sequences this. `ST_RUN` is normal sequential flow. `ST_SLOT` means the current instruction is a delay slot and the parked target will be issued next. Three transitions exist: `RUN_STAY` (`ST_RUN` to `ST_RUN`, when nothing is taken), `RUN_ARM` (`ST_RUN` to `ST_SLOT`, on a taken transfer) and `SLOT_FIRE` (`ST_SLOT` to `ST_RUN`, always). Reset returns the machine to `ST_RUN` and discards any pending target.

Top module: `npc_unit`

## Requirements
- R1: In `ST_RUN`, an instruction that is not a control transfer, or a conditional branch whose test fails, gives `next_pc_o = pc_i + 4`, and no pending target is armed.
- R2: A taken transfer gives `next_pc_o = pc_i + 4` in its own cycle, so the delay slot executes. In the following cycle, whatever the slot instruction is, `next_pc_o` is the transfer's target, and the machine is back in `ST_RUN` after that.
- R3: A conditional branch target is (`pc_i` + 4) plus the 16-bit field `insn_i[15:0]`, sign-extended and multiplied by 4.
- R4: Opcode `insn_i[31:26]` = 000100 is taken when `rs_val_i == rt_val_i`. Opcode 000101 is taken when they differ.
- R5: Opcode 000111 is taken when `rs_val_i` is greater than zero. Opcode 000110 is taken when `rs_val_i` is less than or equal to zero. Both tests treat the value as signed two's complement.
- R6: Opcode 000001 takes a sub-code from `insn_i[20:16]`. 00000 is taken when `rs_val_i` is negative. 00001 is taken when it is zero or positive. 10000 and 10001 perform the same two tests with link. Every other sub-code is not a transfer.
- R7: Opcode 000010 (jump) and opcode 000011 (jump with link) always transfer. Their target is `{pc_i[31:28], insn_i[25:0], 2'b00}`.
- R8: Opcode 000000 with function code `insn_i[5:0]` = 001000 always transfers, to `rs_val_i`. Other function codes under opcode 000000 are not transfers.
- R9: Sub-codes 10000 and 10001 under opcode 000001, and opcode 000011, raise `link_we_o` in their own cycle only, with `link_val_o = pc_i + 8`. This happens whether or not the condition holds.
- R10: While in `ST_SLOT`, the control fields of the slot instruction are ignored. It raises no `link_we_o` and arms no new target.
- R11: While `rst_n` is low, and after it rises, the machine is in `ST_RUN` with nothing pending. Any target pending when reset arrived is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction executes per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | Address of the instruction executing this cycle |
| insn_i | input | 32 | Instruction word at `pc_i` |
| rs_val_i | input | 32 | Value of the register named by `insn_i[25:21]` |
| rt_val_i | input | 32 | Value of the register named by `insn_i[20:16]` |
| next_pc_o | output | 32 | Address to fetch after this instruction |
| link_we_o | output | 1 | Write strobe for the return address into register 31 |
| link_val_o | output | 32 | Return address, `pc_i + 8` |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, 16-bit branch offsets and 26-bit jump indices. With these values, the sign bit of the branch offset and the top four address bits kept by a jump both come within reach. Vectors include a backward branch, and a jump from an address whose upper nibble is nonzero with an all-ones index. Signed zero tests are driven with 0, -1 and the most negative value. A jump-with-link placed in a delay slot, and a reset that arrives while a target is pending, cover the suppression and discard paths.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int WORD_W   = 32;
    localparam int OPC_W    = 6;
    localparam int SUB_W    = 5;
    localparam int FN_W     = 6;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ZCMP    = 6'b000001;
    localparam logic [OPC_W-1:0] OPC_JMP     = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_JMPL    = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_EQ      = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_NE      = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_LEZ     = 6'b000110;
    localparam logic [OPC_W-1:0] OPC_GTZ     = 6'b000111;

    localparam logic [SUB_W-1:0] SUB_NEG     = 5'b00000;
    localparam logic [SUB_W-1:0] SUB_NNEG    = 5'b00001;
    localparam logic [SUB_W-1:0] SUB_NEG_L   = 5'b10000;
    localparam logic [SUB_W-1:0] SUB_NNEG_L  = 5'b10001;

    localparam logic [FN_W-1:0]  FN_JREG     = 6'b001000;

    typedef enum logic [3:0] {
        CF_NONE,
        CF_EQ,
        CF_NE,
        CF_GTZ,
        CF_LEZ,
        CF_NEG,
        CF_NNEG,
        CF_JIDX,
        CF_JREG
    } cf_kind_e;

    typedef struct packed {
        cf_kind_e kind;
        logic     link;
    } cf_ctl_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_SLOT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0] insn_i,
    output cf_ctl_t           ctl_o
);
    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int SUB_LSB = 16;

    logic [OPC_W-1:0] opc;
    logic [SUB_W-1:0] sub;
    logic [FN_W-1:0]  fn;

    assign opc = insn_i[INSN_W-1:OPC_LSB];
    assign sub = insn_i[SUB_LSB +: SUB_W];
    assign fn  = insn_i[FN_W-1:0];

    always_comb begin
        ctl_o.kind = CF_NONE;
        ctl_o.link = 1'b0;
        unique case (opc)
            OPC_EQ:   ctl_o.kind = CF_EQ;
            OPC_NE:   ctl_o.kind = CF_NE;
            OPC_GTZ:  ctl_o.kind = CF_GTZ;
            OPC_LEZ:  ctl_o.kind = CF_LEZ;
            OPC_JMP:  ctl_o.kind = CF_JIDX;
            OPC_JMPL: begin
                ctl_o.kind = CF_JIDX;
                ctl_o.link = 1'b1;
            end
            OPC_ZCMP: begin
                unique case (sub)
                    SUB_NEG:    ctl_o.kind = CF_NEG;
                    SUB_NNEG:   ctl_o.kind = CF_NNEG;
                    SUB_NEG_L: begin
                        ctl_o.kind = CF_NEG;
                        ctl_o.link = 1'b1;
                    end
                    SUB_NNEG_L: begin
                        ctl_o.kind = CF_NNEG;
                        ctl_o.link = 1'b1;
                    end
                    default:    ctl_o.kind = CF_NONE;
                endcase
            end
            OPC_SPECIAL: begin
                if (fn == FN_JREG) ctl_o.kind = CF_JREG;
            end
            default: ctl_o.kind = CF_NONE;
        endcase
    end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cf_kind_e          kind_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              taken_o
);
    logic is_neg;
    logic is_zero;

    assign is_neg  = a_i[DATA_W-1];
    assign is_zero = (a_i == '0);

    always_comb begin
        unique case (kind_i)
            CF_EQ:   taken_o = (a_i == b_i);
            CF_NE:   taken_o = (a_i != b_i);
            CF_GTZ:  taken_o = !is_neg && !is_zero;
            CF_LEZ:  taken_o = is_neg || is_zero;
            CF_NEG:  taken_o = is_neg;
            CF_NNEG: taken_o = !is_neg;
            CF_JIDX: taken_o = 1'b1;
            CF_JREG: taken_o = 1'b1;
            default: taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 26
) (
    input  cf_kind_e          kind_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] seq_pc_i,
    input  logic [ADDR_W-1:0] insn_i,
    input  logic [ADDR_W-1:0] reg_i,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int ALIGN  = 2;
    localparam int REGN_W = ADDR_W - IDX_W - ALIGN;
    localparam int EXT_W  = ADDR_W - OFF_W - ALIGN;

    logic [OFF_W-1:0]  off;
    logic [ADDR_W-1:0] off_scaled;
    logic [ADDR_W-1:0] rel_tgt;
    logic [ADDR_W-1:0] abs_tgt;

    assign off        = insn_i[OFF_W-1:0];
    assign off_scaled = {{EXT_W{off[OFF_W-1]}}, off, {ALIGN{1'b0}}};
    assign rel_tgt    = seq_pc_i + off_scaled;
    assign abs_tgt    = {pc_i[ADDR_W-1 -: REGN_W], insn_i[IDX_W-1:0], {ALIGN{1'b0}}};

    always_comb begin
        unique case (kind_i)
            CF_JIDX: tgt_o = abs_tgt;
            CF_JREG: tgt_o = reg_i;
            default: tgt_o = rel_tgt;
        endcase
    end

endmodule

// File: rtl/npc_seq.sv
module npc_seq
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              link_i,
    input  logic [ADDR_W-1:0] tgt_i,
    input  logic [ADDR_W-1:0] seq_pc_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              link_we_o,
    output logic              in_slot_o
);
    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pend_q, pend_d;

    // next-state selection: RUN_STAY, RUN_ARM, SLOT_FIRE
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_RUN: begin
                if (arm_i) begin
                    state_d = ST_SLOT;
                    pend_d  = tgt_i;
                end
            end
            ST_SLOT: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // outputs
    always_comb begin
        next_pc_o = seq_pc_i;
        link_we_o = 1'b0;
        in_slot_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                next_pc_o = seq_pc_i;
                link_we_o = link_i;
            end
            ST_SLOT: begin
                next_pc_o = pend_q;
                in_slot_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] insn_i,
    input  logic [ADDR_W-1:0] rs_val_i,
    input  logic [ADDR_W-1:0] rt_val_i,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic              link_we_o,
    output logic [ADDR_W-1:0] link_val_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    cf_ctl_t           ctl;
    logic              taken;
    logic              arm;
    logic              in_slot;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] tgt;

    assign seq_pc     = pc_i + STEP;
    assign link_val_o = seq_pc + STEP;
    assign arm        = (ctl.kind != CF_NONE) && taken;

    npc_decode #(.INSN_W(ADDR_W)) u_dec (
        .insn_i (insn_i),
        .ctl_o  (ctl)
    );

    npc_cond #(.DATA_W(ADDR_W)) u_cond (
        .kind_i  (ctl.kind),
        .a_i     (rs_val_i),
        .b_i     (rt_val_i),
        .taken_o (taken)
    );

    npc_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
        .kind_i   (ctl.kind),
        .pc_i     (pc_i),
        .seq_pc_i (seq_pc),
        .insn_i   (insn_i),
        .reg_i    (rs_val_i),
        .tgt_o    (tgt)
    );

    npc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm),
        .link_i    (ctl.link),
        .tgt_i     (tgt),
        .seq_pc_i  (seq_pc),
        .next_pc_o (next_pc_o),
        .link_we_o (link_we_o),
        .in_slot_o (in_slot)
    );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc_i,
    input logic [ADDR_W-1:0] insn_i,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic              link_we_o,
    input logic              in_slot,
    input logic              arm,
    input logic [ADDR_W-1:0] tgt
);
    // R2: an armed transfer outside a slot issues its target in the next cycle
    p_redirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !in_slot) |=> (in_slot && next_pc_o == $past(tgt)));

    // R2: a slot lasts a single cycle
    p_one_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot |=> !in_slot);

    // R1: outside a slot the fetch address steps by one word
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_slot |-> (next_pc_o == pc_i + 32'd4));

    // R10: a slot instruction never links
    p_slot_nolink_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot |-> !link_we_o);

    // R9: only the link opcodes raise the strobe
    p_link_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (insn_i[31:26] == 6'b000011 ||
                       (insn_i[31:26] == 6'b000001 && insn_i[20] == 1'b1)));

    // R11: reset leaves no slot pending
    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> !in_slot);

endmodule

bind npc_unit npc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_i      (pc_i),
    .insn_i    (insn_i),
    .next_pc_o (next_pc_o),
    .link_we_o (link_we_o),
    .in_slot   (in_slot),
    .arm       (arm),
    .tgt       (tgt)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] insn;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] npc;
        logic        we;
        logic [7:0]  req;
    } vec_t;

    function automatic logic [31:0] ei(input logic [5:0] op, input logic [4:0] rt, input logic [15:0] imm);
        return {op, 5'd0, rt, imm};
    endfunction

    function automatic logic [31:0] ej(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction

    function automatic logic [31:0] er(input logic [5:0] fn);
        return {6'd0, 5'd3, 15'd0, fn};
    endfunction

    localparam logic [31:0] NOP = 32'h0;
    localparam int NV = 41;

    localparam vec_t VEC [NV] = '{
        '{32'h1000, NOP,                32'h0, 32'h0, 32'h1004, 1'b0, 8'd1},  // R1
        '{32'h1004, ei(6'd4, 0, 16'd4), 32'd5, 32'd5, 32'h1008, 1'b0, 8'd4},  // R4 eq taken
        '{32'h1008, NOP,                32'h0, 32'h0, 32'h1018, 1'b0, 8'd2},  // R2 slot then target
        '{32'h1018, ei(6'd4, 0, 16'd4), 32'd5, 32'd6, 32'h101C, 1'b0, 8'd4},  // R4 eq not taken
        '{32'h101C, NOP,                32'h0, 32'h0, 32'h1020, 1'b0, 8'd1},  // R1
        '{32'h1020, ei(6'd5, 0, 16'hFFFE), 32'd1, 32'd2, 32'h1024, 1'b0, 8'd4}, // R4 ne taken
        '{32'h1024, NOP,                32'h0, 32'h0, 32'h101C, 1'b0, 8'd3},  // R3 backward
        '{32'h101C, ei(6'd5, 0, 16'd8), 32'd3, 32'd3, 32'h1020, 1'b0, 8'd4},  // R4 ne not taken
        '{32'h1020, ei(6'd7, 0, 16'd2), 32'd1, 32'd0, 32'h1024, 1'b0, 8'd5},  // R5 gtz 1
        '{32'h1024, NOP,                32'h0, 32'h0, 32'h102C, 1'b0, 8'd5},
        '{32'h102C, ei(6'd7, 0, 16'd2), 32'd0, 32'd0, 32'h1030, 1'b0, 8'd5},  // R5 gtz 0
        '{32'h1030, ei(6'd7, 0, 16'd2), 32'h80000000, 32'd0, 32'h1034, 1'b0, 8'd5}, // R5 signed
        '{32'h1034, ei(6'd6, 0, 16'd3), 32'd0, 32'd0, 32'h1038, 1'b0, 8'd5},  // R5 lez 0
        '{32'h1038, NOP,                32'h0, 32'h0, 32'h1044, 1'b0, 8'd5},
        '{32'h1044, ei(6'd6, 0, 16'd1), 32'hFFFFFFFF, 32'd0, 32'h1048, 1'b0, 8'd5}, // R5 lez -1
        '{32'h1048, NOP,                32'h0, 32'h0, 32'h104C, 1'b0, 8'd5},
        '{32'h104C, ei(6'd6, 0, 16'd1), 32'd7, 32'd0, 32'h1050, 1'b0, 8'd5},  // R5 lez 7
        '{32'h1050, ei(6'd1, 5'd0, 16'd4), 32'h80000000, 32'd0, 32'h1054, 1'b0, 8'd6}, // R6 neg
        '{32'h1054, NOP,                32'h0, 32'h0, 32'h1064, 1'b0, 8'd6},
        '{32'h1064, ei(6'd1, 5'd0, 16'd4), 32'd0, 32'd0, 32'h1068, 1'b0, 8'd6}, // R6 neg fails
        '{32'h1068, ei(6'd1, 5'd1, 16'd2), 32'd0, 32'd0, 32'h106C, 1'b0, 8'd6}, // R6 nneg 0
        '{32'h106C, NOP,                32'h0, 32'h0, 32'h1074, 1'b0, 8'd6},
        '{32'h1074, ei(6'd1, 5'd1, 16'd2), 32'hFFFFFFFF, 32'd0, 32'h1078, 1'b0, 8'd6}, // R6 nneg fails
        '{32'h1078, ei(6'd1, 5'd16, 16'd1), 32'hFFFFFFF0, 32'd0, 32'h107C, 1'b1, 8'd9}, // R9 neg link
        '{32'h107C, NOP,                32'h0, 32'h0, 32'h1080, 1'b0, 8'd9},
        '{32'h1080, ei(6'd1, 5'd17, 16'd5), 32'hFFFFFFFF, 32'd0, 32'h1084, 1'b1, 8'd9}, // R9 link untaken
        '{32'h1084, NOP,                32'h0, 32'h0, 32'h1088, 1'b0, 8'd9},
        '{32'h1088, ei(6'd1, 5'd2, 16'd4), 32'd0, 32'd0, 32'h108C, 1'b0, 8'd6}, // R6 bad sub-code
        '{32'h108C, NOP,                32'h0, 32'h0, 32'h1090, 1'b0, 8'd6},
        '{32'h1090, ej(6'd2, 26'h400),  32'h0, 32'h0, 32'h1094, 1'b0, 8'd7},  // R7 jump
        '{32'h1094, NOP,                32'h0, 32'h0, 32'h1000, 1'b0, 8'd7},
        '{32'h1000, ej(6'd3, 26'h800),  32'h0, 32'h0, 32'h1004, 1'b1, 8'd9},  // R9 jump link
        '{32'h1004, NOP,                32'h0, 32'h0, 32'h2000, 1'b0, 8'd7},
        '{32'h2000, er(6'h08),          32'h3000, 32'h0, 32'h2004, 1'b0, 8'd8}, // R8 jreg
        '{32'h2004, NOP,                32'h0, 32'h0, 32'h3000, 1'b0, 8'd8},
        '{32'h3000, er(6'h20),          32'h5000, 32'h0, 32'h3004, 1'b0, 8'd8}, // R8 other fn
        '{32'h3004, ei(6'd4, 0, 16'h10), 32'd0, 32'd0, 32'h3008, 1'b0, 8'd10}, // R10 arm
        '{32'h3008, ej(6'd3, 26'h100),  32'h0, 32'h0, 32'h3048, 1'b0, 8'd10}, // R10 jal in slot
        '{32'h3048, NOP,                32'h0, 32'h0, 32'h304C, 1'b0, 8'd10},
        '{32'hA0000010, ej(6'd2, 26'h3FFFFFF), 32'h0, 32'h0, 32'hA0000014, 1'b0, 8'd7}, // R7 region
        '{32'hA0000014, NOP,            32'h0, 32'h0, 32'hAFFFFFFC, 1'b0, 8'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0, insn_i = '0, rs_val_i = '0, rt_val_i = '0;
    logic [31:0] next_pc_o, link_val_o;
    logic        link_we_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    npc_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_i       (pc_i),
        .insn_i     (insn_i),
        .rs_val_i   (rs_val_i),
        .rt_val_i   (rt_val_i),
        .next_pc_o  (next_pc_o),
        .link_we_o  (link_we_o),
        .link_val_o (link_val_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] pc, input logic [31:0] insn,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        pc_i = pc; insn_i = insn; rs_val_i = a; rt_val_i = b;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state, R11
        drive(32'h100, NOP, 0, 0);
        chk("R11 reset npc", next_pc_o, 32'h104);
        chk("R11 reset link", {31'd0, link_we_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].pc, VEC[i].insn, VEC[i].a, VEC[i].b);
            chk($sformatf("R%0d vec%0d npc", VEC[i].req, i), next_pc_o, VEC[i].npc);
            chk($sformatf("R%0d vec%0d link_we", VEC[i].req, i), {31'd0, link_we_o}, {31'd0, VEC[i].we});
            if (VEC[i].we)
                chk($sformatf("R9 vec%0d link_val", i), link_val_o, VEC[i].pc + 32'd8);
        end

        // R11: reset while a target is pending discards it
        drive(32'h4000, ei(6'd4, 0, 16'h40), 32'd1, 32'd1);
        chk("R2 arm before reset", next_pc_o, 32'h4004);
        @(negedge clk);
        rst_n = 1'b0;
        pc_i = 32'h4004; insn_i = NOP;
        #1;
        chk("R11 pending dropped", next_pc_o, 32'h4008);
        @(negedge clk);
        rst_n = 1'b1;
        drive(32'h4008, NOP, 0, 0);
        chk("R11 run after reset", next_pc_o, 32'h400C);

        // R2 / R10: taken branch in the slot of a jump-register is ignored
        drive(32'h6000, er(6'h08), 32'h7000, 32'h0);
        chk("R8 jreg", next_pc_o, 32'h6004);
        drive(32'h6004, ei(6'd4, 0, 16'h8), 32'd2, 32'd2);
        chk("R10 branch in slot", next_pc_o, 32'h7000);
        drive(32'h7000, NOP, 0, 0);
        chk("R10 slot branch not armed", next_pc_o, 32'h7004);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule